// File: doc/BRIEF.md
# DDR ADC Sample Deserializer

This block takes in two channels from a parallel double-data-rate ADC bus. Each channel has seven data lanes. Every lane carries two bits of each 14-bit sample, one bit per edge of the forwarded clock. The block runs on a bit clock at twice the forwarded-clock rate, so one lane bit arrives per bit-clock cycle. On that clock it rebuilds the samples and groups every four bit periods into a word. Each word holds two consecutive samples, called even and odd. A one-cycle strobe marks each new word, which means the strobe is the clock enable of the slow parallel domain.

Each sample is left-justified to 16 bits and its top bit is inverted, so offset-binary ADC codes come out as two's complement. A select input picks which channel drives the registered outputs. A parameter picks whether the extra downsampled output carries the even or the odd sample, giving a stream at half the sample rate. Two more parameters handle boards that swap the P/N legs. One moves capture to the falling edge of the bit clock. The other inverts every captured lane bit.

Top module: `ddr_adc_deser`

## Requirements
- R1: While `rst_n` is low, `frame_o` is 0 and `even_o`, `odd_o` and `ds_o` are all 0.
- R2: Within one sample period, lane k carries sample bit 2k+1 in its first bit-clock cycle and sample bit 2k in its second. Lane 6 therefore carries bits 13:12 and lane 0 carries bits 1:0.
- R3: Framing starts at the first rising bit-clock edge after reset release. Word w is built from the four bit periods captured at edges 4w to 4w+3, where edge 0 is the last edge still under reset. The first two periods form the even sample and the last two form the odd sample.
- R4: An output sample is formed as follows. Bits [15:2] hold the 14-bit code with bit 15 inverted, and bits [1:0] are 0. For example, code 0x0000 gives 0x8000, 0x3FFF gives 0x7FFC and 0x2000 gives 0x0000.
- R5: `frame_o` is a one-cycle pulse. It goes high after the fifth rising edge following reset release and then repeats every four bit-clock cycles.
- R6: `even_o`, `odd_o` and `ds_o` change only on the edge that raises `frame_o`, and hold their value otherwise. The word reported on pulse p is word p.
- R7: `ch_sel_i` is sampled on the loading edge. At 0 the outputs take the word from `lane_a_i`, and at 1 the word from `lane_b_i`.
- R8: `ds_o` equals `odd_o` when PICK_ODD is 1 and `even_o` when PICK_ODD is 0.
- R9: With CAPTURE_FALL = 1 the lanes are sampled on the falling bit-clock edge. Data presented around the falling edge then yields the same words and the same timing as rising-edge data presented half a cycle earlier.
- R10: With INVERT_LANES = 1 every lane bit is inverted at capture, so a bus driven with all bits complemented reproduces the original samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock, one lane bit per cycle (two per sample) |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with bit_clk |
| lane_a_i | input | 7 | Channel A data lanes |
| lane_b_i | input | 7 | Channel B data lanes |
| ch_sel_i | input | 1 | Channel select, 0 = A, 1 = B |
| frame_o | output | 1 | One-cycle strobe: a new word is on the outputs |
| even_o | output | 16 | Even sample of the selected channel, formatted |
| odd_o | output | 16 | Odd sample of the selected channel, formatted |
| ds_o | output | 16 | Downsampled stream, even or odd per PICK_ODD |

## Verification
The bench goes after codes at the sign boundary: all zeros, all ones, 0x2000 and 0x1FFF. A missing MSB inversion or a shifted justification turns these into values that are plainly wrong. Alternating-bit codes and random samples expose a swapped bit order within a lane pair or a wrong lane index, since even and odd would then come out scrambled or exchanged. The channel select is toggled from word to word to catch a design that routes the wrong channel or latches the select late. A second instance runs with falling-edge capture and inverted lanes against complemented, half-cycle-shifted data. A design that ignored either parameter would return complemented or misaligned samples there.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
  // bit periods gathered into one parallel word (two samples, two bits each)
  localparam int unsigned FRAME_EDGES = 4;
  localparam int unsigned FRAME_CNT_W = $clog2(FRAME_EDGES);
  localparam int unsigned NUM_CH      = 2;
  // positions inside a lane's per-word shift vector, oldest bit highest
  localparam int unsigned EV_HI = FRAME_EDGES - 1;
  localparam int unsigned EV_LO = FRAME_EDGES - 2;
  localparam int unsigned OD_HI = FRAME_EDGES - 3;
  localparam int unsigned OD_LO = FRAME_EDGES - 4;
endpackage

// File: rtl/ddr_frame_timer.sv
module ddr_frame_timer
  import ddr_deser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic word_done_o
);
  logic [FRAME_CNT_W-1:0] cnt_q;
  logic [FRAME_CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign word_done_o = (cnt_q == FRAME_CNT_W'(FRAME_EDGES - 1));

  // R5
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_o |=> !word_done_o);
endmodule

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture #(
  parameter int unsigned LANES  = 7,
  parameter bit          FALL   = 1'b0,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  output logic [LANES-1:0] cap_o
);
  logic [LANES-1:0] cap_d;
  logic [LANES-1:0] cap_q;

  // undo a swapped P/N path by flipping every lane bit
  always_comb begin
    cap_d = lane_i ^ {LANES{INVERT}};
  end

  generate
    if (FALL) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
      end
    end
  endgenerate

  assign cap_o = cap_q;
endmodule

// File: rtl/ddr_channel_deser.sv
module ddr_channel_deser
  import ddr_deser_pkg::*;
#(
  parameter int unsigned LANES  = 7,
  parameter int unsigned OUT_W  = 16,
  parameter bit          FALL   = 1'b0,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             word_done_i,
  output logic [OUT_W-1:0] even_o,
  output logic [OUT_W-1:0] odd_o,
  output logic             pair_vld_o
);
  localparam int unsigned SMP_W = 2 * LANES;
  localparam int unsigned PAD_W = OUT_W - SMP_W;

  logic [LANES-1:0]                  cap;
  logic [LANES-1:0][FRAME_EDGES-1:0] sr_q;
  logic [LANES-1:0][FRAME_EDGES-1:0] sr_d;
  logic [SMP_W-1:0]                  ev_raw;
  logic [SMP_W-1:0]                  od_raw;
  logic [OUT_W-1:0]                  ev_fmt;
  logic [OUT_W-1:0]                  od_fmt;
  logic [OUT_W-1:0]                  ev_q;
  logic [OUT_W-1:0]                  ev_d;
  logic [OUT_W-1:0]                  od_q;
  logic [OUT_W-1:0]                  od_d;
  logic                              vld_q;

  ddr_lane_capture #(
    .LANES  (LANES),
    .FALL   (FALL),
    .INVERT (INVERT)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lane_i (lane_i),
    .cap_o  (cap)
  );

  // per lane: shift in one bit per cycle; earlier bit of a pair is the higher one
  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign sr_d[k]       = {sr_q[k][FRAME_EDGES-2:0], cap[k]};
      assign ev_raw[2*k+1] = sr_d[k][EV_HI];
      assign ev_raw[2*k]   = sr_d[k][EV_LO];
      assign od_raw[2*k+1] = sr_d[k][OD_HI];
      assign od_raw[2*k]   = sr_d[k][OD_LO];
    end
  endgenerate

  // left-justify and flip the top bit: offset binary to two's complement
  generate
    if (PAD_W > 0) begin : g_pad
      assign ev_fmt = {~ev_raw[SMP_W-1], ev_raw[SMP_W-2:0], {PAD_W{1'b0}}};
      assign od_fmt = {~od_raw[SMP_W-1], od_raw[SMP_W-2:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign ev_fmt = {~ev_raw[SMP_W-1], ev_raw[SMP_W-2:0]};
      assign od_fmt = {~od_raw[SMP_W-1], od_raw[SMP_W-2:0]};
    end
  endgenerate

  always_comb begin
    ev_d = ev_q;
    od_d = od_q;
    if (word_done_i) begin
      ev_d = ev_fmt;
      od_d = od_fmt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      ev_q  <= '0;
      od_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      ev_q  <= ev_d;
      od_q  <= od_d;
      vld_q <= word_done_i;
    end
  end

  assign even_o     = ev_q;
  assign odd_o      = od_q;
  assign pair_vld_o = vld_q;

  // R6
  pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done_i |=> ($stable(ev_q) && $stable(od_q)));

  // R5
  pair_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/ddr_adc_deser.sv
module ddr_adc_deser
  import ddr_deser_pkg::*;
#(
  parameter int unsigned LANES        = 7,
  parameter int unsigned OUT_W        = 16,
  parameter bit          CAPTURE_FALL = 1'b0,
  parameter bit          INVERT_LANES = 1'b0,
  parameter bit          PICK_ODD     = 1'b0
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_a_i,
  input  logic [LANES-1:0] lane_b_i,
  input  logic             ch_sel_i,
  output logic             frame_o,
  output logic [OUT_W-1:0] even_o,
  output logic [OUT_W-1:0] odd_o,
  output logic [OUT_W-1:0] ds_o
);
  logic                              word_done;
  logic [NUM_CH-1:0][LANES-1:0]      ch_lanes;
  logic [NUM_CH-1:0][OUT_W-1:0]      ch_even;
  logic [NUM_CH-1:0][OUT_W-1:0]      ch_odd;
  logic [NUM_CH-1:0]                 ch_vld;
  logic [OUT_W-1:0]                  sel_even;
  logic [OUT_W-1:0]                  sel_odd;
  logic [OUT_W-1:0]                  even_q, even_d;
  logic [OUT_W-1:0]                  odd_q, odd_d;
  logic [OUT_W-1:0]                  ds_q, ds_d;
  logic                              frame_q;
  logic                              load_en;

  assign ch_lanes = {lane_b_i, lane_a_i};

  ddr_frame_timer u_timer (
    .clk_i       (bit_clk),
    .rst_ni      (rst_n),
    .word_done_o (word_done)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      ddr_channel_deser #(
        .LANES  (LANES),
        .OUT_W  (OUT_W),
        .FALL   (CAPTURE_FALL),
        .INVERT (INVERT_LANES)
      ) u_ch (
        .clk_i       (bit_clk),
        .rst_ni      (rst_n),
        .lane_i      (ch_lanes[c]),
        .word_done_i (word_done),
        .even_o      (ch_even[c]),
        .odd_o       (ch_odd[c]),
        .pair_vld_o  (ch_vld[c])
      );
    end
  endgenerate

  assign load_en  = ch_vld[0];
  assign sel_even = ch_even[ch_sel_i];
  assign sel_odd  = ch_odd[ch_sel_i];

  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    ds_d   = ds_q;
    if (load_en) begin
      even_d = sel_even;
      odd_d  = sel_odd;
      ds_d   = PICK_ODD ? sel_odd : sel_even;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q  <= '0;
      odd_q   <= '0;
      ds_q    <= '0;
      frame_q <= 1'b0;
    end else begin
      even_q  <= even_d;
      odd_q   <= odd_d;
      ds_q    <= ds_d;
      frame_q <= load_en;
    end
  end

  assign frame_o = frame_q;
  assign even_o  = even_q;
  assign odd_o   = odd_q;
  assign ds_o    = ds_q;

  // R5
  frame_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_q |=> !frame_q);

  // R3
  chan_lock_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    ch_vld[0] == ch_vld[1]);

  // R7
  route_a_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load_en && !ch_sel_i) |=> (even_q == $past(ch_even[0]) && odd_q == $past(ch_odd[0])));

  // R7
  route_b_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load_en && ch_sel_i) |=> (even_q == $past(ch_even[1]) && odd_q == $past(ch_odd[1])));

  // R8
  ds_pick_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_q |-> (ds_q == (PICK_ODD ? odd_q : even_q)));
endmodule

// File: tb/ddr_adc_deser_tb_top.sv
module ddr_adc_deser_tb_top;
  localparam int NSMP   = 400;
  localparam int NWORDS = NSMP / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  la_r, lb_r, la_f, lb_f;
  logic        ch_sel;
  logic        fr0, fr1;
  logic [15:0] ev0, od0, ds0, ev1, od1, ds1;
  logic [13:0] sa [NSMP];
  logic [13:0] sb [NSMP];
  int          checks = 0;
  int          fails  = 0;

  always #5 clk = ~clk;

  // rising-edge capture, straight lanes, even sample on ds
  ddr_adc_deser dut_i (
    .bit_clk (clk), .rst_n (rst_n), .lane_a_i (la_r), .lane_b_i (lb_r),
    .ch_sel_i (ch_sel), .frame_o (fr0), .even_o (ev0), .odd_o (od0), .ds_o (ds0)
  );

  // falling-edge capture, inverted lanes, odd sample on ds
  ddr_adc_deser #(.CAPTURE_FALL(1'b1), .INVERT_LANES(1'b1), .PICK_ODD(1'b1)) dut_inv_i (
    .bit_clk (clk), .rst_n (rst_n), .lane_a_i (la_f), .lane_b_i (lb_f),
    .ch_sel_i (ch_sel), .frame_o (fr1), .even_o (ev1), .odd_o (od1), .ds_o (ds1)
  );

  function automatic logic [6:0] lane_val(logic [13:0] s, bit second);
    logic [6:0] v;
    for (int k = 0; k < 7; k++) v[k] = second ? s[2*k] : s[2*k+1];
    return v;
  endfunction

  function automatic logic [15:0] fmt(logic [13:0] s);
    return {~s[13], s[12:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // stimulus: lane stream plus reset
  initial begin
    void'($urandom(32'd7331));
    for (int m = 0; m < NSMP; m++) begin
      if (m < 10) begin
        case (m)
          2: begin sa[m] = 14'h0000; sb[m] = 14'h3FFF; end
          3: begin sa[m] = 14'h3FFF; sb[m] = 14'h0000; end
          4: begin sa[m] = 14'h2000; sb[m] = 14'h1FFF; end
          5: begin sa[m] = 14'h1FFF; sb[m] = 14'h2000; end
          6: begin sa[m] = 14'h2AAA; sb[m] = 14'h1555; end
          7: begin sa[m] = 14'h1555; sb[m] = 14'h2AAA; end
          8: begin sa[m] = 14'h0001; sb[m] = 14'h3FFE; end
          9: begin sa[m] = 14'h3FFE; sb[m] = 14'h0001; end
          default: begin sa[m] = 14'h0; sb[m] = 14'h0; end
        endcase
      end else if (m < 100) begin
        sa[m] = 14'(m * 131);
        sb[m] = 14'(16383 - m * 97);
      end else begin
        sa[m] = 14'($urandom);
        sb[m] = 14'($urandom);
      end
    end
    rst_n = 1'b0;
    la_r = '0; lb_r = '0; la_f = '1; lb_f = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset frame", {31'b0, fr0}, 32'd0);
    chk("R1 reset even", {16'b0, ev0}, 32'd0);
    chk("R1 reset odd", {16'b0, od0}, 32'd0);
    chk("R1 reset ds", {16'b0, ds1}, 32'd0);
    for (int j = 0; j < 2 * NSMP; j++) begin
      if (j > 0) @(negedge clk);
      #1;
      if (j == 1) rst_n = 1'b1;
      la_r = lane_val(sa[j/2], bit'(j % 2));
      lb_r = lane_val(sb[j/2], bit'(j % 2));
      @(posedge clk);
      #1;
      la_f = ~lane_val(sa[j/2], bit'(j % 2));
      lb_f = ~lane_val(sb[j/2], bit'(j % 2));
    end
  end

  // monitor: compares outputs at falling edges
  initial begin
    int p;
    int cyc;
    bit sel_cur;
    logic [13:0] se, so;
    logic [15:0] h_e0, h_o0, h_d0;
    p = 0; cyc = 0; sel_cur = 1'b0; ch_sel = 1'b0;
    h_e0 = '0; h_o0 = '0; h_d0 = '0;
    @(posedge rst_n);
    while (p < NWORDS) begin
      @(negedge clk);
      cyc++;
      if (fr0) begin
        chk("R5 pulse slot", cyc, 4 * p + 5);
        chk("R9 R10 pulse aligned", {31'b0, fr1}, 32'd1);
        if (p >= 1) begin
          se = sel_cur ? sb[2*p]   : sa[2*p];
          so = sel_cur ? sb[2*p+1] : sa[2*p+1];
          if (p <= 4) begin
            chk(sel_cur ? "R4 R7 corner even ch B" : "R4 corner even ch A", {16'b0, ev0}, {16'b0, fmt(se)});
            chk(sel_cur ? "R4 R7 corner odd ch B" : "R4 corner odd ch A", {16'b0, od0}, {16'b0, fmt(so)});
          end else begin
            chk(sel_cur ? "R2 R3 R7 even ch B" : "R2 R3 even ch A", {16'b0, ev0}, {16'b0, fmt(se)});
            chk(sel_cur ? "R2 R3 R7 odd ch B" : "R2 R3 odd ch A", {16'b0, od0}, {16'b0, fmt(so)});
          end
          chk("R8 ds carries even", {16'b0, ds0}, {16'b0, fmt(se)});
          chk("R9 R10 even", {16'b0, ev1}, {16'b0, fmt(se)});
          chk("R9 R10 odd", {16'b0, od1}, {16'b0, fmt(so)});
          chk("R8 ds carries odd", {16'b0, ds1}, {16'b0, fmt(so)});
        end
        h_e0 = ev0; h_o0 = od0; h_d0 = ds0;
        p++;
        sel_cur = (p % 4 == 2) ? 1'b1 : bit'($urandom % 2);
        ch_sel  = sel_cur;
      end else begin
        chk("R5 no extra pulse", {31'b0, fr1}, 32'd0);
        chk("R6 hold even", {16'b0, ev0}, {16'b0, h_e0});
        chk("R6 hold odd", {16'b0, od0}, {16'b0, h_o0});
        chk("R6 hold ds", {16'b0, ds0}, {16'b0, h_d0});
      end
    end
    summary();
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule